// File: doc/BRIEF.md
# Single-Bit Test Branch Evaluator

This unit resolves a conditional branch whose condition is the value of one bit of a 64-bit register operand. The instruction supplies the bit position (0 to 63) and a polarity flag. With the flag high the branch goes when the chosen bit is 1, and with the flag low it goes when that bit is 0. Alongside the condition, the unit forms the branch destination from the current program counter and a signed 16-bit word offset. It also asks the fetch logic to treat the next 32-bit instruction as a delay slot.

The branch is illegal when it sits in a delay slot or a forbidden slot. In that case the unit raises a reserved-instruction exception and does not set up a branch: taken, the delay-slot request and the target all stay at zero. The unit accepts one request per cycle when `req_valid` is high and presents registered results one cycle later.

Control is a three-state machine. `ST_IDLE` means no result. `ST_BRANCH` means a legal branch was resolved. `ST_TRAP` means the slot rule was broken. Every state follows from the request of the previous cycle. `ST_IDLE` moves to `ST_BRANCH` on a legal request, to `ST_TRAP` on a request made in a slot, and stays in `ST_IDLE` with no request. The same three transitions leave `ST_BRANCH` and `ST_TRAP`, so back-to-back requests move straight between result states.

Top module: `bb_unit`

## Requirements
- R1: After reset `res_valid`, `taken`, `slot_next` and `ri_trap` are 0 and `target` is 0.
- R2: With `pol_set`=1 and the slot flag low, `taken` equals bit `bit_pos` of `operand`.
- R3: With `pol_set`=0 and the slot flag low, `taken` equals the inverse of bit `bit_pos` of `operand`.
- R4: For a legal request, `target` = `pc` + 4 + 4×offset, taken modulo 2^64.
- R5: `offset` is a two's-complement 16-bit word count, sign-extended before scaling (0xFFFF is -4 bytes, 0x8000 is -0x20000 bytes).
- R6: With `in_slot`=1, the next cycle has `ri_trap`=1 and `taken`=0, `slot_next`=0 and `target`=0, whatever the operand bit is.
- R7: A legal request gives `slot_next`=1 in its result cycle.
- R8: Results appear exactly one clock after the strobe. A cycle with no strobe is followed by `res_valid`=0 with all other outputs at 0.
- R9: Requests on consecutive cycles each produce their own result on consecutive cycles.
- R10: Bit positions 0 and 63 select the least and most significant operand bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| operand | input | 64 | Register value under test |
| bit_pos | input | 6 | Index of the tested bit |
| pol_set | input | 1 | 1: branch on bit set; 0: branch on bit clear |
| offset | input | 16 | Signed word offset |
| pc | input | 64 | Address of the branch instruction |
| in_slot | input | 1 | Branch sits in a delay or forbidden slot |
| res_valid | output | 1 | Result present this cycle |
| taken | output | 1 | Branch condition true |
| target | output | 64 | Branch destination |
| slot_next | output | 1 | Treat the next instruction as a delay slot |
| ri_trap | output | 1 | Reserved-instruction exception |

## Verification
The slot exception and a true branch condition can arise in the same cycle. This happens when a request made in a slot also has its selected bit matching the polarity. The bench provokes it by driving such a request. It judges the result by requiring `ri_trap` high while `taken`, `slot_next` and `target` are all zero. The trap vector sits between legal requests in the back-to-back sequence, so the bench also confirms that the result states pass cleanly into and out of the trap state.

// File: rtl/bb_pkg.sv
package bb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BRANCH = 2'd1,
        ST_TRAP   = 2'd2
    } bb_state_t;
endpackage

// File: rtl/bb_bit_test.sv
module bb_bit_test #(
    parameter int XLEN = 64,
    localparam int POSW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] operand,
    input  logic [POSW-1:0] bit_pos,
    input  logic            pol_set,
    output logic            cond
);
    logic [XLEN-1:0] mask;
    logic            hit;

    always_comb begin
        mask = {{(XLEN-1){1'b0}}, 1'b1} << bit_pos;
        hit  = |(operand & mask);
        cond = pol_set ? hit : ~hit;
    end
endmodule

// File: rtl/bb_target_gen.sv
module bb_target_gen #(
    parameter int XLEN       = 64,
    parameter int OFFW       = 16,
    parameter int INSN_BYTES = 4,
    localparam int SHIFT     = $clog2(INSN_BYTES)
) (
    input  logic [XLEN-1:0] pc,
    input  logic [OFFW-1:0] offset,
    output logic [XLEN-1:0] target
);
    logic [XLEN-1:0] off_ext;
    logic [XLEN-1:0] off_bytes;

    always_comb begin
        off_ext   = {{(XLEN-OFFW){offset[OFFW-1]}}, offset};
        off_bytes = off_ext << SHIFT;
        target    = pc + XLEN'(INSN_BYTES) + off_bytes;
    end
endmodule

// File: rtl/bb_ctrl.sv
module bb_ctrl
    import bb_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            in_slot,
    input  logic            cond,
    input  logic [XLEN-1:0] tgt,
    output logic            res_valid,
    output logic            taken,
    output logic [XLEN-1:0] target,
    output logic            slot_next,
    output logic            ri_trap
);
    bb_state_t       state_q, state_d;
    logic            cond_q;
    logic [XLEN-1:0] tgt_q;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_BRANCH, ST_TRAP: begin
                if (req_valid && in_slot)  state_d = ST_TRAP;
                else if (req_valid)        state_d = ST_BRANCH;
                else                       state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cond_q  <= 1'b0;
            tgt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                cond_q <= cond;
                tgt_q  <= tgt;
            end
        end
    end

    always_comb begin
        res_valid = 1'b0;
        taken     = 1'b0;
        target    = '0;
        slot_next = 1'b0;
        ri_trap   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_BRANCH: begin
                res_valid = 1'b1;
                taken     = cond_q;
                target    = tgt_q;
                slot_next = 1'b1;
            end
            ST_TRAP: begin
                res_valid = 1'b1;
                ri_trap   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bb_unit.sv
module bb_unit #(
    parameter int XLEN = 64,
    parameter int OFFW = 16,
    localparam int POSW = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [XLEN-1:0] operand,
    input  logic [POSW-1:0] bit_pos,
    input  logic            pol_set,
    input  logic [OFFW-1:0] offset,
    input  logic [XLEN-1:0] pc,
    input  logic            in_slot,
    output logic            res_valid,
    output logic            taken,
    output logic [XLEN-1:0] target,
    output logic            slot_next,
    output logic            ri_trap
);
    logic            cond;
    logic [XLEN-1:0] tgt;

    bb_bit_test #(.XLEN(XLEN)) u_test (
        .operand (operand),
        .bit_pos (bit_pos),
        .pol_set (pol_set),
        .cond    (cond)
    );

    bb_target_gen #(.XLEN(XLEN), .OFFW(OFFW), .INSN_BYTES(4)) u_tgt (
        .pc     (pc),
        .offset (offset),
        .target (tgt)
    );

    bb_ctrl #(.XLEN(XLEN)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .in_slot   (in_slot),
        .cond      (cond),
        .tgt       (tgt),
        .res_valid (res_valid),
        .taken     (taken),
        .target    (target),
        .slot_next (slot_next),
        .ri_trap   (ri_trap)
    );
endmodule

// File: rtl/bb_unit_chk.sv
module bb_unit_chk #(
    parameter int XLEN = 64,
    parameter int OFFW = 16,
    localparam int POSW = $clog2(XLEN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [XLEN-1:0] operand,
    input logic [POSW-1:0] bit_pos,
    input logic            pol_set,
    input logic [OFFW-1:0] offset,
    input logic [XLEN-1:0] pc,
    input logic            in_slot,
    input logic            res_valid,
    input logic            taken,
    input logic [XLEN-1:0] target,
    input logic            slot_next,
    input logic            ri_trap
);
    p_trap_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ri_trap |-> (!taken && !slot_next && target == '0));

    p_trap_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && in_slot) |=> ri_trap);

    p_slot_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !in_slot) |=> (slot_next && !ri_trap));

    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!res_valid && !taken && !slot_next && !ri_trap));

    p_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !in_slot) |=>
            target == $past(pc) + XLEN'(4)
                      + ({{(XLEN-OFFW){$past(offset[OFFW-1])}}, $past(offset)} << 2));

    p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({slot_next, ri_trap}));
endmodule

bind bb_unit bb_unit_chk #(.XLEN(XLEN), .OFFW(OFFW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .operand   (operand),
    .bit_pos   (bit_pos),
    .pol_set   (pol_set),
    .offset    (offset),
    .pc        (pc),
    .in_slot   (in_slot),
    .res_valid (res_valid),
    .taken     (taken),
    .target    (target),
    .slot_next (slot_next),
    .ri_trap   (ri_trap)
);

// File: tb/bb_unit_tb.sv
module bb_unit_tb;
    typedef struct packed {
        logic [63:0] op;
        logic [5:0]  pos;
        logic        pol;
        logic [15:0] off;
        logic [63:0] pc;
        logic        slot;
        logic        e_taken;
        logic [63:0] e_tgt;
        logic        e_ds;
        logic        e_trap;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        // R2 bit 4 set, polarity set
        '{64'h10, 6'd4, 1'b1, 16'h0003, 64'h1000, 1'b0, 1'b1, 64'h1010, 1'b1, 1'b0},
        // R2 bit 5 clear, polarity set
        '{64'h10, 6'd5, 1'b1, 16'h0000, 64'h2000, 1'b0, 1'b0, 64'h2004, 1'b1, 1'b0},
        // R3 R5 R10 bit 0 clear, polarity clear, offset -1
        '{64'h0, 6'd0, 1'b0, 16'hFFFF, 64'h1000, 1'b0, 1'b1, 64'h1000, 1'b1, 1'b0},
        // R3 R5 R10 bit 63 set, polarity clear, most negative offset
        '{64'hFFFF_FFFF_FFFF_FFFF, 6'd63, 1'b0, 16'h8000, 64'h40000, 1'b0, 1'b0, 64'h20004, 1'b1, 1'b0},
        // R6 slot request whose condition would be true
        '{64'h1, 6'd0, 1'b1, 16'h0005, 64'h3000, 1'b1, 1'b0, 64'h0, 1'b0, 1'b1},
        // R10 R4 bit 63, largest positive offset
        '{64'h8000_0000_0000_0000, 6'd63, 1'b1, 16'h7FFF, 64'h0, 1'b0, 1'b1, 64'h20000, 1'b1, 1'b0},
        // R4 address wraps to zero
        '{64'h0, 6'd10, 1'b1, 16'h0000, 64'hFFFF_FFFF_FFFF_FFFC, 1'b0, 1'b0, 64'h0, 1'b1, 1'b0},
        // R3 bit 32 set, polarity clear
        '{64'h1_0000_0000, 6'd32, 1'b0, 16'h0010, 64'h100, 1'b0, 1'b0, 64'h144, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] operand = '0;
    logic [5:0]  bit_pos = '0;
    logic        pol_set = 1'b0;
    logic [15:0] offset = '0;
    logic [63:0] pc = '0;
    logic        in_slot = 1'b0;
    logic        res_valid, taken, slot_next, ri_trap;
    logic [63:0] target;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bb_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .operand(operand),
        .bit_pos(bit_pos), .pol_set(pol_set), .offset(offset), .pc(pc),
        .in_slot(in_slot), .res_valid(res_valid), .taken(taken),
        .target(target), .slot_next(slot_next), .ri_trap(ri_trap)
    );

    task automatic check(string req, logic v, logic t, logic [63:0] g, logic d, logic x);
        checks++;
        if (res_valid !== v || taken !== t || target !== g || slot_next !== d || ri_trap !== x) begin
            errors++;
            $display("FAIL %s: got v=%b t=%b tgt=%h ds=%b trap=%b exp v=%b t=%b tgt=%h ds=%b trap=%b",
                     req, res_valid, taken, target, slot_next, ri_trap, v, t, g, d, x);
        end
    endtask

    task automatic drive(vec_t vv);
        req_valid = 1'b1;
        operand = vv.op; bit_pos = vv.pos; pol_set = vv.pol;
        offset = vv.off; pc = vv.pc; in_slot = vv.slot;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 1'b0, 1'b0, 64'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", 1'b0, 1'b0, 64'h0, 1'b0, 1'b0);

        // back-to-back table walk: R2 R3 R4 R5 R6 R7 R9 R10
        for (int i = 0; i <= NV; i++) begin
            if (i > 0)
                check("R2 R3 R4 R5 R6 R7 R9 R10 table", 1'b1, VECS[i-1].e_taken,
                      VECS[i-1].e_tgt, VECS[i-1].e_ds, VECS[i-1].e_trap);
            if (i < NV) drive(VECS[i]);
            else req_valid = 1'b0;
            @(negedge clk);
        end
        check("R8 no strobe", 1'b0, 1'b0, 64'h0, 1'b0, 1'b0);

        // R6 slot flag ignored when no strobe
        in_slot = 1'b1;
        @(negedge clk);
        check("R8 slot without strobe", 1'b0, 1'b0, 64'h0, 1'b0, 1'b0);

        // R8 isolated request: result only in the following cycle
        drive(VECS[0]);
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 single result", 1'b1, 1'b1, 64'h1010, 1'b1, 1'b0);
        @(negedge clk);
        check("R8 result lasts one cycle", 1'b0, 1'b0, 64'h0, 1'b0, 1'b0);

        // R6 trap after a branch, then R7 branch after trap
        drive(VECS[4]);
        @(negedge clk);
        check("R6 isolated trap", 1'b1, 1'b0, 64'h0, 1'b0, 1'b1);
        drive(VECS[2]);
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 branch after trap", 1'b1, 1'b1, 64'h1000, 1'b1, 1'b0);

        // R1 reset during activity
        drive(VECS[5]);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", 1'b0, 1'b0, 64'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        check("R1 after re-reset", 1'b0, 1'b0, 64'h0, 1'b0, 1'b0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung expected completion");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule